// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block converts a logical address, made of a 16-bit segment selector and a 32-bit offset, into a flat 32-bit linear address. It keeps a small file of segment registers. Each register holds a cached copy of a segment descriptor: the base, the effective limit and the read and write rights.

Software loads a selector into a segment register through the load port. The block then reads the 8-byte descriptor that the selector names from either the global or the local descriptor table. It reads the two 32-bit words over a valid/ready memory read port, checks them, and fills the cache entry.

After that, every access through the register needs no memory traffic. The offset is compared with the cached limit, the rights are checked against the access direction, and the base is added to the offset. All of this happens in one registered step. While a register is being reloaded, accesses through that register are held off. Accesses through the other registers continue.

Top module: `seg_xlate`

## Requirements
- R1: An accepted access that passes its checks gives `lin_valid`=1 on the cycle after acceptance, with `lin_addr` equal to the cached base plus the offset, wrapping modulo 2^32.
- R2: Selector bit 2 picks the table (0 = global, 1 = local). Bits 15:3 are the entry index. The two descriptor words are read from table base + index*8 and from table base + index*8 + 4, in that order.
- R3: A load whose last descriptor byte (index*8+7) lies above the chosen table's byte limit ends with `ld_done`=1 and `ld_fault`=1. It issues no memory read and leaves the segment register unchanged.
- R4: A load whose descriptor has the present bit clear ends with `ld_fault`=1 and leaves the segment register unchanged.
- R5: The first descriptor word is the base. In the second word, bits 19:0 hold the limit. When the granularity bit is 0, an access with an offset above the limit faults, and an offset equal to the limit passes.
- R6: Bit 20 of the second word is the granularity bit. When it is 1, the effective limit is (limit << 12) | FFFh.
- R7: Bit 21 of the second word grants writes and bit 22 grants reads. A write to a segment without the write right faults, and so does a read from a segment without the read right.
- R8: While a descriptor fetch for segment register s is in progress, `acc_ready` is 0 for accesses to s and 1 for accesses to any other register. No new load is accepted during the fetch.
- R9: `acc_fault` and `lin_valid` are never both 1. An access through a register that has never been loaded successfully faults.
- R10: A memory request holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready`. Only one request is outstanding at a time.
- R11: After reset, `ld_ready`=1 and `lin_valid`, `acc_fault`, `ld_done`, `ld_fault` and `mem_req_valid` are all 0.
- R12: Bit 23 of the second word is the present bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gtab_base | input | 32 | Global table base address |
| gtab_lim | input | 16 | Global table byte limit |
| ltab_base | input | 32 | Local table base address |
| ltab_lim | input | 16 | Local table byte limit |
| ld_valid | input | 1 | Load request |
| ld_seg | input | 3 | Segment register to load |
| ld_sel | input | 16 | Selector to load |
| ld_ready | output | 1 | Load port can accept |
| ld_done | output | 1 | Load finished (one-cycle pulse) |
| ld_fault | output | 1 | Finished load was rejected |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| acc_valid | input | 1 | Access request |
| acc_seg | input | 3 | Segment register used |
| acc_off | input | 32 | Offset |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ready | output | 1 | Access can be accepted |
| lin_valid | output | 1 | Linear address valid |
| lin_addr | output | 32 | Linear address |
| acc_fault | output | 1 | Access rejected |

## Verification
The properties assume the memory returns exactly one `mem_rsp_valid` pulse for each accepted request, and never one without a request. They also assume the load and access inputs hold steady while their ready signal is low. The bench memory model answers each accepted request once, after one or two cycles, and withholds `mem_req_ready` on a repeating pattern so that request holding is exercised. The drivers change inputs only at the falling edge and keep them in place until acceptance. No access to a register is issued in the same cycle as a load of that register.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   localparam int LIN_W = 32;
   localparam int SEL_W = 16;

   // field positions in the second descriptor word
   localparam int D_LIM_LSB = 0;
   localparam int D_GRAN    = 20;
   localparam int D_WR      = 21;
   localparam int D_RD      = 22;
   localparam int D_PRES    = 23;

   // selector fields
   localparam int S_TABLE   = 2;
   localparam int S_IDX_LSB = 3;

   typedef struct packed {
      logic             vld;
      logic [LIN_W-1:0] base;
      logic [LIN_W-1:0] elim;
      logic             wr;
      logic             rd;
   } seg_ent_t;

   typedef enum logic [2:0] {
      F_IDLE  = 3'd0,
      F_REQ0  = 3'd1,
      F_WAIT0 = 3'd2,
      F_REQ1  = 3'd3,
      F_WAIT1 = 3'd4
   } fetch_st_t;
endpackage

// File: rtl/seg_fetch.sv
module seg_fetch
   import seg_xlate_pkg::*;
#(
   parameter int SEG_IW  = 3,
   parameter int TLIM_W  = 16,
   parameter int LIM_W   = 20,
   parameter int GRAN_SH = 12,
   parameter bit GRAN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LIN_W-1:0]  gtab_base,
   input  logic [TLIM_W-1:0] gtab_lim,
   input  logic [LIN_W-1:0]  ltab_base,
   input  logic [TLIM_W-1:0] ltab_lim,
   input  logic              ld_valid,
   input  logic [SEG_IW-1:0] ld_seg,
   input  logic [SEL_W-1:0]  ld_sel,
   output logic              ld_ready,
   output logic              ld_done,
   output logic              ld_fault,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [LIN_W-1:0]  mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [LIN_W-1:0]  mem_rsp_data,
   output logic              busy,
   output logic [SEG_IW-1:0] fseg,
   output logic              wr_en,
   output seg_ent_t          wr_ent
);
   localparam int IDX_W = SEL_W - S_IDX_LSB;
   localparam int EXT_W = LIM_W + GRAN_SH;
   localparam int TOP_W = SEL_W + 1;

   fetch_st_t           st_q;
   logic [LIN_W-1:0]    daddr_q;
   logic [LIN_W-1:0]    w0_q;
   logic [SEG_IW-1:0]   fseg_q;
   logic                done_q, fault_q;

   logic [IDX_W-1:0]    idx;
   logic                use_local;
   logic [TOP_W-1:0]    last_byte;
   logic [TOP_W-1:0]    tab_lim_ext;
   logic [LIN_W-1:0]    tab_base;
   logic                tab_over;
   logic [LIN_W-1:0]    daddr;
   logic [LIM_W-1:0]    lim;
   logic                gran, present;
   logic [LIN_W-1:0]    elim;
   logic                unused_sel;
   logic                unused_hi;

   assign idx         = ld_sel[SEL_W-1:S_IDX_LSB];
   assign use_local   = ld_sel[S_TABLE];
   assign unused_sel  = ^ld_sel[S_TABLE-1:0];
   assign last_byte   = TOP_W'({idx, 3'b111});
   assign tab_lim_ext = TOP_W'(use_local ? ltab_lim : gtab_lim);
   assign tab_base    = use_local ? ltab_base : gtab_base;
   assign tab_over    = last_byte > tab_lim_ext;
   assign daddr       = tab_base + LIN_W'({idx, 3'b000});

   assign lim     = mem_rsp_data[D_LIM_LSB +: LIM_W];
   assign gran    = mem_rsp_data[D_GRAN];
   assign present = mem_rsp_data[D_PRES];
   assign unused_hi = ^mem_rsp_data[LIN_W-1:D_PRES+1];

   generate
      if (GRAN_EN) begin : g_gran
         assign elim = gran ? LIN_W'({lim, {GRAN_SH{1'b1}}}) : LIN_W'(lim);
      end else begin : g_bytes
         logic unused_gran;
         assign unused_gran = gran;
         assign elim = LIN_W'(lim);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= F_IDLE;
         daddr_q <= '0;
         w0_q    <= '0;
         fseg_q  <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         case (st_q)
            F_IDLE: begin
               if (ld_valid) begin
                  fseg_q <= ld_seg;
                  if (tab_over) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                  end else begin
                     daddr_q <= daddr;
                     st_q    <= F_REQ0;
                  end
               end
            end
            F_REQ0:  if (mem_req_ready) st_q <= F_WAIT0;
            F_WAIT0: begin
               if (mem_rsp_valid) begin
                  w0_q <= mem_rsp_data;
                  st_q <= F_REQ1;
               end
            end
            F_REQ1:  if (mem_req_ready) st_q <= F_WAIT1;
            F_WAIT1: begin
               if (mem_rsp_valid) begin
                  done_q  <= 1'b1;
                  fault_q <= ~present;
                  st_q    <= F_IDLE;
               end
            end
            default: st_q <= F_IDLE;
         endcase
      end
   end

   assign ld_ready      = (st_q == F_IDLE);
   assign ld_done       = done_q;
   assign ld_fault      = fault_q;
   assign busy          = (st_q != F_IDLE);
   assign fseg          = fseg_q;
   assign mem_req_valid = (st_q == F_REQ0) || (st_q == F_REQ1);
   assign mem_req_addr  = (st_q == F_REQ1) ? daddr_q + LIN_W'(4) : daddr_q;

   assign wr_en       = (st_q == F_WAIT1) && mem_rsp_valid && present;
   assign wr_ent.vld  = 1'b1;
   assign wr_ent.base = w0_q;
   assign wr_ent.elim = elim;
   assign wr_ent.wr   = mem_rsp_data[D_WR];
   assign wr_ent.rd   = mem_rsp_data[D_RD];
endmodule

// File: rtl/seg_cache.sv
module seg_cache
   import seg_xlate_pkg::*;
#(
   parameter int NSEG   = 6,
   parameter int SEG_IW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEG_IW-1:0] wr_idx,
   input  seg_ent_t          wr_ent,
   input  logic [SEG_IW-1:0] rd_idx,
   output seg_ent_t          rd_ent
);
   seg_ent_t ents [NSEG];

   generate
      for (genvar i = 0; i < NSEG; i++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ents[i] <= '0;
            end else if (wr_en && (wr_idx == SEG_IW'(i))) begin
               ents[i] <= wr_ent;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_ent = '0;
      for (int i = 0; i < NSEG; i++) begin
         if (rd_idx == SEG_IW'(i)) rd_ent = ents[i];
      end
   end
endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
(
   input  seg_ent_t         ent,
   input  logic [LIN_W-1:0] off,
   input  logic             is_write,
   output logic             ok,
   output logic [LIN_W-1:0] lin
);
   logic in_range;
   logic right_ok;

   assign in_range = off <= ent.elim;
   assign right_ok = is_write ? ent.wr : ent.rd;
   assign ok       = ent.vld && in_range && right_ok;
   assign lin      = ent.base + off;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int NSEG    = 6,
   parameter int SEG_IW  = 3,
   parameter int TLIM_W  = 16,
   parameter int LIM_W   = 20,
   parameter int GRAN_SH = 12,
   parameter bit GRAN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       gtab_base,
   input  logic [TLIM_W-1:0] gtab_lim,
   input  logic [31:0]       ltab_base,
   input  logic [TLIM_W-1:0] ltab_lim,
   input  logic              ld_valid,
   input  logic [SEG_IW-1:0] ld_seg,
   input  logic [15:0]       ld_sel,
   output logic              ld_ready,
   output logic              ld_done,
   output logic              ld_fault,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [31:0]       mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   input  logic              acc_valid,
   input  logic [SEG_IW-1:0] acc_seg,
   input  logic [31:0]       acc_off,
   input  logic              acc_write,
   output logic              acc_ready,
   output logic              lin_valid,
   output logic [31:0]       lin_addr,
   output logic              acc_fault
);
   generate
      if (NSEG < 1 || NSEG > (1 << SEG_IW)) begin : g_bad_nseg
         $error("seg_xlate: NSEG must fit in SEG_IW bits");
      end
      if (LIM_W + GRAN_SH > LIN_W) begin : g_bad_lim
         $error("seg_xlate: scaled limit wider than linear address");
      end
      if (TLIM_W < 3 || TLIM_W > SEL_W) begin : g_bad_tlim
         $error("seg_xlate: table limit width out of range");
      end
      if (D_PRES >= LIN_W - 1) begin : g_bad_fields
         $error("seg_xlate: descriptor flag layout does not fit");
      end
   endgenerate

   logic              busy;
   logic [SEG_IW-1:0] fseg;
   logic              wr_en;
   seg_ent_t          wr_ent;
   seg_ent_t          rd_ent;
   logic              chk_ok;
   logic [LIN_W-1:0]  chk_lin;
   logic              acc_take;
   logic              lv_q, af_q;
   logic [LIN_W-1:0]  la_q;

   seg_fetch #(
      .SEG_IW (SEG_IW),
      .TLIM_W (TLIM_W),
      .LIM_W  (LIM_W),
      .GRAN_SH(GRAN_SH),
      .GRAN_EN(GRAN_EN)
   ) u_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .gtab_base    (gtab_base),
      .gtab_lim     (gtab_lim),
      .ltab_base    (ltab_base),
      .ltab_lim     (ltab_lim),
      .ld_valid     (ld_valid),
      .ld_seg       (ld_seg),
      .ld_sel       (ld_sel),
      .ld_ready     (ld_ready),
      .ld_done      (ld_done),
      .ld_fault     (ld_fault),
      .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready),
      .mem_req_addr (mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .busy         (busy),
      .fseg         (fseg),
      .wr_en        (wr_en),
      .wr_ent       (wr_ent)
   );

   seg_cache #(
      .NSEG  (NSEG),
      .SEG_IW(SEG_IW)
   ) u_cache (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wr_idx(fseg),
      .wr_ent(wr_ent),
      .rd_idx(acc_seg),
      .rd_ent(rd_ent)
   );

   seg_check u_check (
      .ent     (rd_ent),
      .off     (acc_off),
      .is_write(acc_write),
      .ok      (chk_ok),
      .lin     (chk_lin)
   );

   assign acc_ready = !(busy && (acc_seg == fseg));
   assign acc_take  = acc_valid && acc_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lv_q <= 1'b0;
         af_q <= 1'b0;
         la_q <= '0;
      end else begin
         lv_q <= acc_take && chk_ok;
         af_q <= acc_take && !chk_ok;
         if (acc_take && chk_ok) la_q <= chk_lin;
      end
   end

   assign lin_valid = lv_q;
   assign acc_fault = af_q;
   assign lin_addr  = la_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int SEG_IW = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_ready,
   input logic              ld_done,
   input logic              ld_fault,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [31:0]       mem_req_addr,
   input logic              acc_valid,
   input logic [SEG_IW-1:0] acc_seg,
   input logic              acc_ready,
   input logic              lin_valid,
   input logic              acc_fault,
   input logic              busy,
   input logic [SEG_IW-1:0] fseg
);
   AST_EXCL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !(lin_valid && acc_fault)); // R9
   AST_ACC_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_ready |=> (lin_valid || acc_fault)); // R1
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid); // R10
   AST_STALL_SEG: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (acc_seg == fseg) |-> !acc_ready); // R8
   AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ld_ready); // R8
   AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_fault |-> ld_done); // R4
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_IW(SEG_IW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ld_ready     (ld_ready),
   .ld_done      (ld_done),
   .ld_fault     (ld_fault),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_addr (mem_req_addr),
   .acc_valid    (acc_valid),
   .acc_seg      (acc_seg),
   .acc_ready    (acc_ready),
   .lin_valid    (lin_valid),
   .acc_fault    (acc_fault),
   .busy         (busy),
   .fseg         (fseg)
);

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] gtab_base = 32'h0000_1000;
   logic [15:0] gtab_lim  = 16'h003F;
   logic [31:0] ltab_base = 32'h0000_8000;
   logic [15:0] ltab_lim  = 16'h0017;
   logic        ld_valid = 1'b0;
   logic [2:0]  ld_seg = '0;
   logic [15:0] ld_sel = '0;
   logic        ld_ready, ld_done, ld_fault;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        acc_valid = 1'b0;
   logic [2:0]  acc_seg = '0;
   logic [31:0] acc_off = '0;
   logic        acc_write = 1'b0;
   logic        acc_ready, lin_valid, acc_fault;
   logic [31:0] lin_addr;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   seg_xlate u0 (.*);

   // ---------------- memory model ----------------
   logic [31:0] mem [logic [31:0]];
   logic [31:0] req_log [$];
   logic [31:0] pend = '0;
   int          rsp_cnt = 0;
   int          tick = 0;

   function automatic logic [31:0] rd_word(logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return 32'h0;
   endfunction

   always @(negedge clk) begin
      tick++;
      mem_rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
         rsp_cnt--;
         if (rsp_cnt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd_word(pend);
         end
      end
      mem_req_ready = (tick % 3) != 1;
      if (mem_req_valid && mem_req_ready) begin
         pend = mem_req_addr;
         req_log.push_back(mem_req_addr);
         rsp_cnt = 1 + (tick % 2);
      end
   end

   task automatic set_desc(input logic [31:0] tb, input int idx, input logic [31:0] base,
                           input logic [19:0] lim, input logic g, input logic w,
                           input logic r, input logic p);
      mem[tb + 32'(idx * 8)]     = base;
      mem[tb + 32'(idx * 8 + 4)] = {8'h00, p, r, w, g, lim};
   endtask

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- scoreboard ----------------
   logic        exp_f_q [$];
   logic [31:0] exp_l_q [$];
   string       tag_q   [$];

   always @(negedge clk) begin
      if (rst_n && (lin_valid || acc_fault)) begin
         if (exp_f_q.size() == 0) begin
            chk(1'b0, "R9 unexpected result", {31'h0, acc_fault}, 32'h0);
         end else begin
            logic        ef;
            logic [31:0] el;
            string       tg;
            ef = exp_f_q.pop_front();
            el = exp_l_q.pop_front();
            tg = tag_q.pop_front();
            chk(acc_fault == ef && lin_valid == !ef, tg, {31'h0, acc_fault}, {31'h0, ef});
            if (!ef) chk(lin_addr == el, tg, lin_addr, el);
         end
      end
   end

   task automatic acc(input logic [2:0] s, input logic [31:0] off, input logic w,
                      input logic ef, input logic [31:0] el, input string tag);
      @(negedge clk);
      acc_valid = 1'b1; acc_seg = s; acc_off = off; acc_write = w;
      #0.1;
      while (!acc_ready) begin
         @(negedge clk);
         #0.1;
      end
      exp_f_q.push_back(ef);
      exp_l_q.push_back(el);
      tag_q.push_back(tag);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic do_ld(input logic [2:0] s, input logic [15:0] sel, input logic ef,
                        input string tag);
      @(negedge clk);
      ld_valid = 1'b1; ld_seg = s; ld_sel = sel;
      while (!ld_ready) @(negedge clk);
      @(negedge clk);
      ld_valid = 1'b0;
      while (!ld_done) @(negedge clk);
      chk(ld_fault == ef, tag, {31'h0, ld_fault}, {31'h0, ef});
   endtask

   initial begin
      // G1: base 0010_0000, limit FFF, byte, rw
      set_desc(32'h1000, 1, 32'h0010_0000, 20'h00FFF, 1'b0, 1'b1, 1'b1, 1'b1);
      // G2: base FFFF_F000, limit 10, 4 KiB units, read-only
      set_desc(32'h1000, 2, 32'hFFFF_F000, 20'h00010, 1'b1, 1'b0, 1'b1, 1'b1);
      // G3: not present
      set_desc(32'h1000, 3, 32'h2222_0000, 20'h0FFFF, 1'b0, 1'b1, 1'b1, 1'b0);
      // L2: base 4000_0000, limit FF, write-only
      set_desc(32'h8000, 2, 32'h4000_0000, 20'h000FF, 1'b0, 1'b1, 1'b0, 1'b1);

      repeat (3) @(negedge clk);
      chk(ld_ready == 1'b1, "R11 ld_ready", {31'h0, ld_ready}, 32'h1);
      chk(!lin_valid && !acc_fault && !ld_done && !ld_fault && !mem_req_valid,
          "R11 idle outputs", {27'h0, lin_valid, acc_fault, ld_done, ld_fault, mem_req_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      acc(3'd0, 32'h10, 1'b0, 1'b1, 32'h0, "R9 unloaded register");

      req_log.delete();
      do_ld(3'd0, 16'h0008, 1'b0, "R2 load global idx1");
      chk(req_log.size() == 2, "R2 word count", 32'(req_log.size()), 32'd2);
      if (req_log.size() == 2) begin
         chk(req_log[0] == 32'h1008, "R2 first word addr", req_log[0], 32'h1008);
         chk(req_log[1] == 32'h100C, "R2 second word addr", req_log[1], 32'h100C);
      end
      acc(3'd0, 32'h10,  1'b0, 1'b0, 32'h0010_0010, "R1 read translate");
      acc(3'd0, 32'hFFF, 1'b1, 1'b0, 32'h0010_0FFF, "R5 offset at limit");
      acc(3'd0, 32'h1000, 1'b0, 1'b1, 32'h0, "R5 offset over limit");

      do_ld(3'd1, 16'h0010, 1'b0, "R6 load scaled segment");
      acc(3'd1, 32'h2000,  1'b0, 1'b0, 32'h0000_1000, "R1 wrap modulo 2^32");
      acc(3'd1, 32'h10FFF, 1'b0, 1'b0, 32'h0000_FFFF, "R6 scaled limit edge");
      acc(3'd1, 32'h11000, 1'b0, 1'b1, 32'h0, "R6 past scaled limit");
      acc(3'd1, 32'h20,    1'b1, 1'b1, 32'h0, "R7 write to read-only");

      req_log.delete();
      do_ld(3'd2, 16'h0014, 1'b0, "R2 load local idx2");
      if (req_log.size() == 2)
         chk(req_log[0] == 32'h8010 && req_log[1] == 32'h8014, "R2 local table addr",
             req_log[0], 32'h8010);
      else
         chk(1'b0, "R2 local word count", 32'(req_log.size()), 32'd2);
      acc(3'd2, 32'h40, 1'b0, 1'b1, 32'h0, "R7 read from write-only");
      acc(3'd2, 32'hFF, 1'b1, 1'b0, 32'h4000_00FF, "R7 write allowed");

      do_ld(3'd0, 16'h0018, 1'b1, "R4 R12 not present");
      acc(3'd0, 32'h10, 1'b0, 1'b0, 32'h0010_0010, "R4 register kept");

      req_log.delete();
      do_ld(3'd0, 16'h0040, 1'b1, "R3 global index past limit");
      chk(req_log.size() == 0, "R3 no memory read", 32'(req_log.size()), 32'd0);
      do_ld(3'd3, 16'h001C, 1'b1, "R3 local index past limit");
      chk(req_log.size() == 0, "R3 no memory read local", 32'(req_log.size()), 32'd0);
      acc(3'd0, 32'h20, 1'b0, 1'b0, 32'h0010_0020, "R3 register kept");
      acc(3'd3, 32'h0,  1'b0, 1'b1, 32'h0, "R3 failed load leaves invalid");

      // R8: stall during fetch of seg1, seg0 proceeds
      @(negedge clk);
      ld_valid = 1'b1; ld_seg = 3'd1; ld_sel = 16'h0008;
      @(negedge clk);
      ld_valid = 1'b0;
      acc_valid = 1'b1; acc_seg = 3'd1; acc_off = 32'h4; acc_write = 1'b0;
      #0.1;
      chk(acc_ready == 1'b0, "R8 stall same segment", {31'h0, acc_ready}, 32'h0);
      chk(ld_ready == 1'b0, "R8 no load during fetch", {31'h0, ld_ready}, 32'h0);
      acc_seg = 3'd0;
      #0.1;
      chk(acc_ready == 1'b1, "R8 other segment ready", {31'h0, acc_ready}, 32'h1);
      exp_f_q.push_back(1'b0);
      exp_l_q.push_back(32'h0010_0004);
      tag_q.push_back("R8 other segment translated");
      @(negedge clk);
      acc_valid = 1'b0;
      while (!ld_done) @(negedge clk);
      chk(ld_fault == 1'b0, "R8 reload result", {31'h0, ld_fault}, 32'h0);
      acc(3'd1, 32'h4, 1'b1, 1'b0, 32'h0010_0004, "R8 reloaded descriptor used");

      repeat (4) @(negedge clk);
      chk(exp_f_q.size() == 0, "R1 all results seen", 32'(exp_f_q.size()), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule